// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This unit stores a time-of-day alarm setting in three byte registers (minutes, hours and day of the week) and compares it with the running BCD time supplied by a clock core. Each register has a mask bit in its top bit that removes that field from the comparison. The mask settings give four alarm modes: weekly with no masks, daily with the day masked, hourly with day and hours masked, and every minute with all three masked.

The clock core pulses an evaluation strobe once per minute, when seconds roll from 59 to 00, and presents the new minute, hour and day on that cycle. The comparison takes place only on that strobe. A match sets a sticky alarm flag. An interrupt line follows the flag, and its polarity is set by a configuration input. Software clears the flag by reading or writing any of the three alarm registers. The registers are reached through a simple strobe-based port with address, read strobe, write strobe and data.

Top module: `tod_alarm`

## Requirements
- R1: After reset the alarm flag is 0, the interrupt is inactive, and all three alarm registers read 0x00.
- R2: The minute alarm register (address 3) and the hour alarm register (address 5) store all 8 written bits. Read data appears on the read port one clock after the read strobe and holds until the next read.
- R3: The day alarm register (address 7) keeps bit 7 (mask) and bits 2:0 (day 1..7). Bits 6:3 always read 0.
- R4: With no mask bit set, the flag sets on an evaluation strobe only when minutes, hours and day all equal the stored values.
- R5: With only the day mask (address 7, bit 7) set, the flag sets on a strobe when minutes and hours match, whatever the day.
- R6: With the day and hour masks set, the flag sets on a strobe when minutes (bits 6:0) match, whatever the hour and day.
- R7: With all three masks set, the flag sets on every evaluation strobe.
- R8: Without an evaluation strobe the flag never sets, even when the current time equals the alarm setting.
- R9: Once set, the flag stays set until reset or until an alarm register access.
- R10: A read or write of address 3, 5 or 7 clears the flag on the next clock. Accesses to other addresses leave it unchanged. A match on the same cycle as an access sets the flag, so the alarm is not lost.
- R11: When the polarity input is 1, the interrupt equals the flag (active-high). When it is 0, the interrupt is the inverse of the flag (active-low).
- R12: Hours compare on bits 6:0, including the 12/24-hour select bit 6 and the PM bit 5. For example, stored 0x71 (11 PM) does not match 0x51 (11 AM).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD with 12/24 and PM bits |
| cur_day | input | 8 | Current day of week, 1..7 |
| eval_tick | input | 1 | One-cycle strobe at each seconds 59-to-00 rollover |
| reg_addr | input | 6 | Register port address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq_pol_high | input | 1 | 1 = active-high interrupt, 0 = active-low interrupt |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a register access that falls on the same cycle as a matching evaluation strobe. Set-over-clear priority can only be seen there. The bench drives the read strobe and the strobe together in one cycle and checks that the flag stays set. Proving that nothing happens without the strobe is also hard. To cover it, the bench holds the current time equal to the alarm setting for several cycles with the strobe low, then checks that the flag is still clear.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
   localparam int BYTE_W = 8;
   localparam int VAL_W  = BYTE_W - 1;
   localparam int NFIELD = 3;

   typedef struct packed {
      logic             mask;
      logic [VAL_W-1:0] val;
   } alm_field_t;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_MIN  = 2'd1,
      SEL_HR   = 2'd2,
      SEL_DAY  = 2'd3
   } alm_sel_e;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
   import tod_alarm_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int MIN_ADDR = 3,
   parameter int HR_ADDR  = 5,
   parameter int DAY_ADDR = 7,
   parameter int DAY_W    = 3,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output alm_field_t        min_f,
   output alm_field_t        hr_f,
   output alm_field_t        day_f,
   output logic              acc_hit
);
   localparam int PAD_W = VAL_W - DAY_W;

   alm_sel_e          sel;
   logic [BYTE_W-1:0] min_q;
   logic [BYTE_W-1:0] hr_q;
   logic              day_mask_q;
   logic [DAY_W-1:0]  day_val_q;
   logic [BYTE_W-1:0] rd_mux;

   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(MIN_ADDR))      sel = SEL_MIN;
      else if (addr == ADDR_W'(HR_ADDR))  sel = SEL_HR;
      else if (addr == ADDR_W'(DAY_ADDR)) sel = SEL_DAY;
   end

   assign acc_hit = (rd_en | wr_en) & (sel != SEL_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min_q      <= '0;
         hr_q       <= '0;
         day_mask_q <= 1'b0;
         day_val_q  <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_MIN: min_q <= wdata;
            SEL_HR:  hr_q  <= wdata;
            SEL_DAY: begin
               day_mask_q <= wdata[BYTE_W-1];
               day_val_q  <= wdata[DAY_W-1:0];
            end
            default: ;
         endcase
      end
   end

   assign min_f = min_q;
   assign hr_f  = hr_q;
   assign day_f = {day_mask_q, {PAD_W{1'b0}}, day_val_q};

   always_comb begin
      case (sel)
         SEL_MIN: rd_mux = min_q;
         SEL_HR:  rd_mux = hr_q;
         SEL_DAY: rd_mux = day_f;
         default: rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [BYTE_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rdata_q <= '0;
            else if (rd_en) rdata_q <= rd_mux;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_en ? rd_mux : '0;
      end
   endgenerate
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
   import tod_alarm_pkg::*;
#(
   parameter int DAY_W = 3
) (
   input  alm_field_t        min_f,
   input  alm_field_t        hr_f,
   input  alm_field_t        day_f,
   input  logic [BYTE_W-1:0] cur_min,
   input  logic [BYTE_W-1:0] cur_hour,
   input  logic [BYTE_W-1:0] cur_day,
   output logic              hit
);
   localparam logic [VAL_W-1:0] FULL_KEEP = '1;
   localparam logic [VAL_W-1:0] DAY_KEEP  = VAL_W'((1 << DAY_W) - 1);

   alm_field_t        fld [NFIELD];
   logic [VAL_W-1:0]  cur [NFIELD];
   logic [NFIELD-1:0] fld_ok;

   assign fld[0] = min_f;
   assign fld[1] = hr_f;
   assign fld[2] = day_f;
   assign cur[0] = cur_min[VAL_W-1:0];
   assign cur[1] = cur_hour[VAL_W-1:0];
   assign cur[2] = cur_day[VAL_W-1:0];

   generate
      for (genvar i = 0; i < NFIELD; i++) begin : g_fld
         localparam logic [VAL_W-1:0] KEEP = (i == NFIELD - 1) ? DAY_KEEP : FULL_KEEP;
         assign fld_ok[i] = fld[i].mask | ((fld[i].val & KEEP) == (cur[i] & KEEP));
      end
   endgenerate

   assign hit = &fld_ok;
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic eval_tick,
   input  logic hit,
   input  logic clr,
   input  logic pol_high,
   output logic flag,
   output logic irq
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (eval_tick && hit) flag_q <= 1'b1;
      else if (clr)              flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = pol_high ? flag_q : ~flag_q;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
   import tod_alarm_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int MIN_ADDR = 3,
   parameter int HR_ADDR  = 5,
   parameter int DAY_ADDR = 7,
   parameter int DAY_W    = 3,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cur_min,
   input  logic [7:0]        cur_hour,
   input  logic [7:0]        cur_day,
   input  logic              eval_tick,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              irq_pol_high,
   output logic              alarm_flag,
   output logic              alarm_irq
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (MIN_ADDR >= ADDR_SPAN || HR_ADDR >= ADDR_SPAN || DAY_ADDR >= ADDR_SPAN) begin : g_bad_addr
         initial $fatal(1, "alarm address outside register port range");
      end
      if (MIN_ADDR == HR_ADDR || MIN_ADDR == DAY_ADDR || HR_ADDR == DAY_ADDR) begin : g_dup_addr
         initial $fatal(1, "alarm addresses must differ");
      end
      if (DAY_W < 1 || DAY_W >= VAL_W) begin : g_bad_day
         initial $fatal(1, "day field width out of range");
      end
   endgenerate

   alm_field_t min_f, hr_f, day_f;
   logic       acc_hit;
   logic       hit;

   tod_alarm_regs #(
      .ADDR_W(ADDR_W), .MIN_ADDR(MIN_ADDR), .HR_ADDR(HR_ADDR),
      .DAY_ADDR(DAY_ADDR), .DAY_W(DAY_W), .READ_REG(READ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .rd_en(reg_rd), .wr_en(reg_wr),
      .wdata(reg_wdata), .rdata(reg_rdata), .min_f(min_f), .hr_f(hr_f),
      .day_f(day_f), .acc_hit(acc_hit)
   );

   tod_alarm_match #(.DAY_W(DAY_W)) u_match (
      .min_f(min_f), .hr_f(hr_f), .day_f(day_f), .cur_min(cur_min),
      .cur_hour(cur_hour), .cur_day(cur_day), .hit(hit)
   );

   tod_alarm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick), .hit(hit), .clr(acc_hit),
      .pol_high(irq_pol_high), .flag(alarm_flag), .irq(alarm_irq)
   );
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk #(
   parameter int ADDR_W   = 6,
   parameter int MIN_ADDR = 3,
   parameter int HR_ADDR  = 5,
   parameter int DAY_ADDR = 7,
   parameter bit READ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eval_tick,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic [7:0]        reg_rdata,
   input logic              irq_pol_high,
   input logic              alarm_flag,
   input logic              alarm_irq,
   input logic              all_masked
);
   logic alm_acc;
   assign alm_acc = (reg_rd || reg_wr) &&
                    (reg_addr == ADDR_W'(MIN_ADDR) || reg_addr == ADDR_W'(HR_ADDR) ||
                     reg_addr == ADDR_W'(DAY_ADDR));

   // R10
   clr_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_acc && !eval_tick) |=> !alarm_flag);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !alm_acc) |=> alarm_flag);

   // R8
   no_set_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_flag && !eval_tick) |=> !alarm_flag);

   // R7
   every_minute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_tick && all_masked) |=> alarm_flag);

   // R11
   irq_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq == (irq_pol_high ? alarm_flag : !alarm_flag));

   generate
      if (READ_REG) begin : g_pad
         // R3
         day_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == ADDR_W'(DAY_ADDR)) |=> (reg_rdata[6:3] == 4'd0));
      end
   endgenerate
endmodule

bind tod_alarm tod_alarm_chk #(
   .ADDR_W(ADDR_W), .MIN_ADDR(MIN_ADDR), .HR_ADDR(HR_ADDR),
   .DAY_ADDR(DAY_ADDR), .READ_REG(READ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .eval_tick(eval_tick), .reg_addr(reg_addr),
   .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
   .irq_pol_high(irq_pol_high), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq),
   .all_masked(min_f.mask & hr_f.mask & day_f.mask)
);

// File: tb/sim_tod_alarm.sv
module sim_tod_alarm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cur_min = '0, cur_hour = '0, cur_day = '0;
   logic       eval_tick = 1'b0;
   logic [5:0] reg_addr = '0;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_pol_high = 1'b1;
   logic       alarm_flag, alarm_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   tod_alarm u0 (
      .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_day(cur_day), .eval_tick(eval_tick), .reg_addr(reg_addr),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_pol_high(irq_pol_high),
      .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic tick(input logic [7:0] m, input logic [7:0] h, input logic [7:0] dy);
      @(negedge clk);
      cur_min = m; cur_hour = h; cur_day = dy; eval_tick = 1'b1;
      @(negedge clk);
      eval_tick = 1'b0;
   endtask

   task automatic clear_flag();
      logic [7:0] d;
      rd(6'd3, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 flag", {7'd0, alarm_flag}, 8'h00);
      chk("R1 irq", {7'd0, alarm_irq}, 8'h00);
      rd(6'd3, d); chk("R1 min reg", d, 8'h00);
      rd(6'd5, d); chk("R1 hr reg", d, 8'h00);
      rd(6'd7, d); chk("R1 day reg", d, 8'h00);
   endtask

   task automatic t_rw();
      logic [7:0] d;
      wr(6'd3, 8'hC5); rd(6'd3, d); chk("R2 min rw", d, 8'hC5);
      wr(6'd5, 8'h92); rd(6'd5, d); chk("R2 hr rw", d, 8'h92);
      repeat (3) @(negedge clk);
      chk("R2 rdata hold", reg_rdata, 8'h92);
      wr(6'd7, 8'hFD); rd(6'd7, d); chk("R3 day pad", d, 8'h85);
      wr(6'd9, 8'h11); rd(6'd3, d); chk("R2 other addr no effect", d, 8'hC5);
   endtask

   task automatic t_exact();
      wr(6'd3, 8'h30); wr(6'd5, 8'h14); wr(6'd7, 8'h03);
      tick(8'h30, 8'h14, 8'h02); chk("R4 day differs", {7'd0, alarm_flag}, 8'h00);
      tick(8'h30, 8'h15, 8'h03); chk("R4 hour differs", {7'd0, alarm_flag}, 8'h00);
      tick(8'h31, 8'h14, 8'h03); chk("R4 min differs", {7'd0, alarm_flag}, 8'h00);
      tick(8'h30, 8'h14, 8'h03); chk("R4 full match", {7'd0, alarm_flag}, 8'h01);
      clear_flag(); chk("R10 read clears", {7'd0, alarm_flag}, 8'h00);
   endtask

   task automatic t_daily();
      wr(6'd7, 8'h83);
      tick(8'h30, 8'h14, 8'h06); chk("R5 daily any day", {7'd0, alarm_flag}, 8'h01);
      clear_flag();
      tick(8'h29, 8'h14, 8'h06); chk("R5 min differs", {7'd0, alarm_flag}, 8'h00);
   endtask

   task automatic t_hourly();
      wr(6'd5, 8'h94); wr(6'd7, 8'h80);
      tick(8'h30, 8'h09, 8'h01); chk("R6 hourly", {7'd0, alarm_flag}, 8'h01);
      wr(6'd3, 8'h30); chk("R10 write clears", {7'd0, alarm_flag}, 8'h00);
      tick(8'h31, 8'h09, 8'h01); chk("R6 min differs", {7'd0, alarm_flag}, 8'h00);
   endtask

   task automatic t_every();
      wr(6'd3, 8'hB0);
      tick(8'h12, 8'h07, 8'h02); chk("R7 every minute a", {7'd0, alarm_flag}, 8'h01);
      clear_flag();
      tick(8'h45, 8'h22, 8'h05); chk("R7 every minute b", {7'd0, alarm_flag}, 8'h01);
      clear_flag();
   endtask

   task automatic t_tick_and_sticky();
      logic [7:0] d;
      wr(6'd3, 8'h30); wr(6'd5, 8'h14); wr(6'd7, 8'h03);
      @(negedge clk);
      cur_min = 8'h30; cur_hour = 8'h14; cur_day = 8'h03;
      repeat (4) @(negedge clk);
      chk("R8 no strobe no flag", {7'd0, alarm_flag}, 8'h00);
      tick(8'h30, 8'h14, 8'h03);
      repeat (5) @(negedge clk);
      chk("R9 flag sticky", {7'd0, alarm_flag}, 8'h01);
      wr(6'd11, 8'h00);
      chk("R10 other addr keeps flag", {7'd0, alarm_flag}, 8'h01);
      rd(6'd4, d);
      chk("R10 other read keeps flag", {7'd0, alarm_flag}, 8'h01);
      clear_flag();
      @(negedge clk);
      reg_addr = 6'd5; reg_rd = 1'b1; eval_tick = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0; eval_tick = 1'b0;
      chk("R10 set wins over clear", {7'd0, alarm_flag}, 8'h01);
      clear_flag();
   endtask

   task automatic t_12h();
      wr(6'd3, 8'h00); wr(6'd5, 8'h71); wr(6'd7, 8'h80);
      tick(8'h00, 8'h51, 8'h01); chk("R12 AM vs PM", {7'd0, alarm_flag}, 8'h00);
      tick(8'h00, 8'h11, 8'h01); chk("R12 24h vs 12h", {7'd0, alarm_flag}, 8'h00);
      tick(8'h00, 8'h71, 8'h01); chk("R12 PM match", {7'd0, alarm_flag}, 8'h01);
      clear_flag();
   endtask

   task automatic t_pol();
      @(negedge clk); irq_pol_high = 1'b0;
      @(negedge clk);
      chk("R11 low idle", {7'd0, alarm_irq}, 8'h01);
      tick(8'h00, 8'h71, 8'h04);
      chk("R11 low active", {7'd0, alarm_irq}, 8'h00);
      irq_pol_high = 1'b1;
      @(negedge clk);
      chk("R11 high active", {7'd0, alarm_irq}, 8'h01);
      clear_flag();
      chk("R11 high idle", {7'd0, alarm_irq}, 8'h00);
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rw();
      t_exact();
      t_daily();
      t_hourly();
      t_every();
      t_tick_and_sticky();
      t_12h();
      t_pol();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule